// File: doc/BRIEF.md
# Byte-at-a-time CRC-16 frame check engine

This block computes the 16-bit frame check sequence used by infrared serial links. Software feeds it one byte per register write. The engine folds each byte into a running 16-bit remainder in a single clock and keeps a count of the bytes absorbed since the last clear. The count appears in the control register. The check value is read from a separate result register.

The block connects to a 16-bit register port with a two-bit address. Address 0 is the control register. Address 1 is the byte input register. Address 2 is the result register. Address 3 is unused.

Every write completes in the cycle it is presented, so the port never stalls the writer and has no ready signal. Reads are combinational and leave all state unchanged. A clear followed by the four bytes 0xCC, 0xF5, 0xF1, 0xA7 gives a known result. Software can use this sequence as a power-on self-test.

Top module: `fcs16_engine`

## Requirements
- R1: After rst_n is released, a read of address 0 returns 0x0000 and a read of address 2 returns 0x0000. Internally the remainder holds 0xFFFF and the count holds 0.
- R2: A write to address 0 with bit 15 set restores the remainder to 0xFFFF and the count to 0. Both values are visible on the next cycle.
- R3: A write to address 0 with bit 15 clear has no effect on either the count or the result.
- R4: Each write to address 1 increases the count by one. A read of address 0 returns the count in bits 11:0, with bits 15:12 reading 0.
- R5: A write to address 1 folds only wdata bits 7:0 into the remainder. The fold handles the least significant bit first and uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1). Bits 15:8 of the write are ignored.
- R6: A read of address 2 returns the bitwise complement of the remainder. The result is valid on the cycle after the last byte is written.
- R7: After a clear, writing the bytes 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4 and a result of 0x51DF.
- R8: The count saturates at 0xFFF. Further byte writes hold it there and still update the remainder.
- R9: A read of address 1 or address 3 returns 0x0000. No read changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 byte input, 2 result |
| reg_wr | input | 1 | Write strobe, accepted in the same cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |

## Verification
A wrong remainder stays hidden until the result register is read. After that it cannot recover, because every later byte is folded into the corrupted value. For this reason the bench reads the result after every single byte of several random streams, and not only at the end. A fault in the count shows up in the control register on the cycle after the faulty write. The saturation boundary and the clear path are checked directly at the cycles where they take effect.

// File: rtl/fcs16_pkg.sv
package fcs16_pkg;
  localparam int REM_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int REG_W    = 16;
  localparam int CLR_BIT  = 15;
  localparam logic [REM_W-1:0] POLY_REFL = 16'h8408;
  localparam logic [REM_W-1:0] SEED      = 16'hFFFF;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BYTE = 2'd1,
    SEL_FCS  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fcs16_fold.sv
module fcs16_fold
  import fcs16_pkg::*;
#(
  parameter int W = REM_W,
  parameter int B = BYTE_W,
  parameter logic [W-1:0] POLY = POLY_REFL
) (
  input  logic [W-1:0] rem_in,
  input  logic [B-1:0] din,
  output logic [W-1:0] rem_out
);
  logic [W-1:0] stage [0:B];

  assign stage[0] = rem_in;

  for (genvar k = 0; k < B; k++) begin : g_bit
    logic fb;
    assign fb = stage[k][0] ^ din[k];
    assign stage[k+1] = (stage[k] >> 1) ^ (fb ? POLY : '0);
  end

  assign rem_out = stage[B];
endmodule

// File: rtl/fcs16_counter.sv
module fcs16_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && count != CMAX)  count <= count + 1'b1;
  end

  a_r8_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && count == CMAX) |=> count == CMAX);
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && count != CMAX) |=> count == $past(count) + 1'b1);
  a_r2_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/fcs16_engine.sv
module fcs16_engine
  import fcs16_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  localparam int PAD_W = REG_W - CNT_W;

  logic             wr_ctrl, wr_byte, do_clr;
  logic [REM_W-1:0] rem_q, rem_next;
  logic [CNT_W-1:0] count;

  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_byte = reg_wr && (reg_addr == SEL_BYTE);
  assign do_clr  = wr_ctrl && reg_wdata[CLR_BIT];

  fcs16_fold #(.W(REM_W), .B(BYTE_W), .POLY(POLY_REFL)) i_fold (
    .rem_in (rem_q),
    .din    (reg_wdata[BYTE_W-1:0]),
    .rem_out(rem_next)
  );

  fcs16_counter #(.CW(CNT_W)) i_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (do_clr),
    .inc  (wr_byte),
    .count(count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rem_q <= SEED;
    else if (do_clr)  rem_q <= SEED;
    else if (wr_byte) rem_q <= rem_next;
  end

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_CTRL: reg_rdata = {{PAD_W{1'b0}}, count};
      SEL_FCS:  reg_rdata = ~rem_q;
      default:  reg_rdata = '0;
    endcase
  end

  a_r2_rem_seed: assert property (@(posedge clk) disable iff (!rst_n)
    do_clr |=> rem_q == SEED);
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_byte && !do_clr) |=> ($stable(rem_q) && $stable(count)));
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == SEL_BYTE || reg_addr == SEL_NONE) |-> reg_rdata == '0);
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == SEL_CTRL |-> reg_rdata[REG_W-1:CNT_W] == '0);
endmodule

// File: tb/test_fcs16_engine.sv
module test_fcs16_engine;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;

  int n_run = 0, n_fail = 0;
  logic [15:0] ref_rem;
  int          ref_cnt;
  logic [15:0] got;

  fcs16_engine i_fcs16_engine (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] ref_fold(logic [15:0] r, logic [7:0] b);
    logic [15:0] x;
    x = r ^ {8'h00, b};
    for (int i = 0; i < 8; i++)
      x = x[0] ? ((x >> 1) ^ 16'h8408) : (x >> 1);
    return x;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic feed(logic [15:0] d);
    wr(2'd1, d);
    ref_rem = ref_fold(ref_rem, d[7:0]);
    if (ref_cnt < 4095) ref_cnt++;
  endtask

  task automatic clear();
    wr(2'd0, 16'h8000);
    ref_rem = 16'hFFFF; ref_cnt = 0;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ref_rem = 16'hFFFF; ref_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(2'd0, got); check("R1 count", got, 16'h0000);
    rd(2'd2, got); check("R1 result", got, 16'h0000);

    // R7 self-test vector
    clear();
    feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
    rd(2'd0, got); check("R7 count", got, 16'd4);
    rd(2'd2, got); check("R7 result", got, 16'h51DF);

    // R3 control write without clear bit
    wr(2'd0, 16'h7FFF);
    rd(2'd0, got); check("R3 count", got, 16'd4);
    rd(2'd2, got); check("R3 result", got, 16'h51DF);

    // R9 unused reads, and reads do not disturb state
    rd(2'd1, got); check("R9 byte addr", got, 16'h0000);
    rd(2'd3, got); check("R9 addr3", got, 16'h0000);
    wr(2'd3, 16'hFFFF);
    rd(2'd2, got); check("R9 result kept", got, 16'h51DF);

    // R2 clear
    clear();
    rd(2'd0, got); check("R2 count", got, 16'h0000);
    rd(2'd2, got); check("R2 result", got, 16'h0000);

    // R5 upper bits ignored
    feed(16'hAB5A);
    rd(2'd2, got); check("R5 upper ignored", got, ~ref_fold(16'hFFFF, 8'h5A));

    // R4 R5 R6 random streams, checked after each byte
    for (int s = 0; s < 5; s++) begin
      clear();
      for (int k = 0; k < 10 + s * 7; k++) begin
        feed(16'($urandom));
        rd(2'd2, got); check("R6 R5 result", got, ~ref_rem);
        rd(2'd0, got); check("R4 count", got, 16'(ref_cnt));
      end
    end

    // R8 saturation
    clear();
    for (int k = 0; k < 4095; k++) feed(16'($urandom));
    rd(2'd0, got); check("R8 at max", got, 16'h0FFF);
    feed(16'h0031); feed(16'h00C2);
    rd(2'd0, got); check("R8 held", got, 16'h0FFF);
    rd(2'd2, got); check("R8 result moves", got, ~ref_rem);

    // R2 clear from saturation
    clear();
    rd(2'd0, got); check("R2 clear sat", got, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule